// File: doc/BRIEF.md
# Serial Slot-Select Word Transmitter

This block is a host-side sender that pushes a 16-bit selection word to a row of attached modules over a three-wire serial link: an active-low frame strobe, a serial clock and a serial data line. A request arrives on a plain synchronous interface. It is either a start pulse with a parallel word, or a clear pulse that sends an all-zero word. The block then pulls the strobe low and clocks the word out most significant bit first. After that it raises the strobe again and marks the end of the frame with a one-cycle done pulse.

Each bit follows the same pattern. The data line settles while the serial clock is high. The clock then drops low and rises again, and the receiver captures on the rising edge. Every gap is a parameter counted in system-clock cycles: strobe-fall to first clock fall, clock low time, clock high time, and last rising edge to strobe release. The defaults round each minimum up for a 50 MHz system clock.

Sending a zero word after a transfer deselects every module once the link goes quiet. This keeps later traffic on the shared wires from writing to a module by accident.

Top module: `slot_sel_tx`

## Requirements
- R1: Out of reset and between frames the strobe and serial clock are 1, the data line is 0, and busy and done are 0.
- R2: A start or clear sampled at a clock edge while idle makes the strobe 0 and busy 1 right after that same edge.
- R3: The word is sent as exactly 16 bits, bit 15 first down to bit 0. A receiver that captures the data line on each rising serial-clock edge rebuilds the word.
- R4: The data line never changes while the serial clock is low, nor at the edge where the clock rises. It changes only one cycle after a rising edge.
- R5: The first rising serial-clock edge comes SETUP_CYC + CLK_LO_CYC cycles after the strobe falls (4 cycles by default, 80 ns at 50 MHz).
- R6: The clock stays low for CLK_LO_CYC cycles and high for CLK_HI_CYC cycles, so rising edges are CLK_LO_CYC + CLK_HI_CYC cycles apart.
- R7: The strobe returns to 1 exactly HOLD_CYC cycles after the last rising edge (13 cycles by default, 260 ns at 50 MHz).
- R8: Done is a single-cycle pulse in the cycle where the strobe goes back to 1, and busy falls in that same cycle.
- R9: A start or clear that arrives while busy is ignored. The frame in flight keeps its word and no extra frame follows.
- R10: A clear request sends an all-zero word. When clear and start arrive together, clear wins.
- R11: Each frame carries exactly 16 rising serial-clock edges, and the clock is never low while the strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a frame carrying word_i |
| clear_i | input | 1 | Request a frame carrying all zeros |
| word_i | input | WORD_W | Word to send, captured on an accepted start |
| strobe_n_o | output | 1 | Active-low frame strobe |
| sclk_o | output | 1 | Serial clock, idles high, capture on rise |
| sdata_o | output | 1 | Serial data, MSB first |
| busy_o | output | 1 | High while a frame is in flight |
| done_o | output | 1 | One-cycle pulse at frame end |

## Verification
Each fault in the internal state shows up at the pins within the frame it corrupts. A phase-timer slip moves the first rising edge, the edge spacing or the strobe release by at least one cycle. The bench measures all of these in cycles from the strobe's fall. A bit counter or shift register that goes wrong changes the rebuilt word, or the number of rising edges, by the end of that frame. A start or clear that is accepted while busy shows as a wrong word or as a second frame within a few cycles of done.

// File: rtl/sst_pkg.sv
package sst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_HOLD
  } sst_state_e;

  function automatic int unsigned at_least(input int unsigned v, input int unsigned lo);
    return (v < lo) ? lo : v;
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/sst_timer.sv
module sst_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sst_shreg.sv
module sst_shreg #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              shift_i,
  input  logic              clr_i,
  output logic              msb_o,
  output logic              last_o
);
  localparam int BC_W = $clog2(WORD_W + 1);
  localparam logic [BC_W-1:0] LAST_IDX = BC_W'(WORD_W - 1);

  logic [WORD_W-1:0] sr_q;
  logic [BC_W-1:0]   shifts_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      sr_q     <= '0;
      shifts_q <= '0;
    end else if (load_i) begin
      sr_q     <= word_i;
      shifts_q <= '0;
    end else if (shift_i) begin
      sr_q     <= {sr_q[WORD_W-2:0], 1'b0};
      shifts_q <= shifts_q + 1'b1;
    end
  end

  assign msb_o  = sr_q[WORD_W-1];
  assign last_o = (shifts_q == LAST_IDX);
endmodule

// File: rtl/sst_ctrl.sv
module sst_ctrl
  import sst_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int SETUP  = 2,
  parameter int LO     = 2,
  parameter int HI     = 3,
  parameter int HOLD   = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic             zero_i,
  input  logic             last_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             sh_load_o,
  output logic             sh_shift_o,
  output logic             sh_clr_o,
  output logic             strobe_n_o,
  output logic             sclk_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] V_SETUP = CNT_W'(SETUP - 1);
  localparam logic [CNT_W-1:0] V_LO    = CNT_W'(LO - 1);
  localparam logic [CNT_W-1:0] V_HI    = CNT_W'(HI - 1);
  localparam logic [CNT_W-1:0] V_HOLD  = CNT_W'(HOLD - 1);

  sst_state_e state_q;
  logic       hi_first_q;
  logic       go;

  assign go = (state_q == ST_IDLE) && req_i;

  always_comb begin
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    if (go) begin
      tmr_load_o = 1'b1;
      tmr_val_o  = V_SETUP;
    end else if (zero_i) begin
      unique case (state_q)
        ST_SETUP, ST_HIGH: begin
          tmr_load_o = 1'b1;
          tmr_val_o  = V_LO;
        end
        ST_LOW: begin
          tmr_load_o = 1'b1;
          tmr_val_o  = last_i ? V_HOLD : V_HI;
        end
        default: ;
      endcase
    end
  end

  assign sh_load_o  = go;
  assign sh_shift_o = (state_q == ST_HIGH) && hi_first_q;
  assign sh_clr_o   = (state_q == ST_HOLD) && zero_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      hi_first_q <= 1'b0;
      strobe_n_o <= 1'b1;
      sclk_o     <= 1'b1;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (go) begin
            state_q    <= ST_SETUP;
            strobe_n_o <= 1'b0;
            busy_o     <= 1'b1;
          end
        end
        ST_SETUP: begin
          if (zero_i) begin
            state_q <= ST_LOW;
            sclk_o  <= 1'b0;
          end
        end
        ST_LOW: begin
          if (zero_i) begin
            sclk_o     <= 1'b1;
            state_q    <= last_i ? ST_HOLD : ST_HIGH;
            hi_first_q <= !last_i;
          end
        end
        ST_HIGH: begin
          hi_first_q <= 1'b0;
          if (zero_i) begin
            sclk_o  <= 1'b0;
            state_q <= ST_LOW;
          end
        end
        ST_HOLD: begin
          if (zero_i) begin
            state_q    <= ST_IDLE;
            strobe_n_o <= 1'b1;
            busy_o     <= 1'b0;
            done_o     <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slot_sel_tx.sv
module slot_sel_tx #(
  parameter int WORD_W     = 16,
  parameter int SETUP_CYC  = 2,
  parameter int CLK_LO_CYC = 2,
  parameter int CLK_HI_CYC = 3,
  parameter int HOLD_CYC   = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              clear_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              strobe_n_o,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int SETUP_E = sst_pkg::at_least(SETUP_CYC, 1);
  localparam int LO_E    = sst_pkg::at_least(CLK_LO_CYC, 1);
  localparam int HI_E    = sst_pkg::at_least(CLK_HI_CYC, 2);
  localparam int HOLD_E  = sst_pkg::at_least(HOLD_CYC, 1);
  localparam int MAX_C   = sst_pkg::max4(SETUP_E, LO_E, HI_E, HOLD_E);
  localparam int CNT_W   = $clog2(MAX_C + 1);

  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             sh_load, sh_shift, sh_clr, sh_last;
  logic [WORD_W-1:0] load_word;

  assign load_word = clear_i ? '0 : word_i;

  sst_timer #(.CNT_W(CNT_W)) timer_i (
    .clk        (clk),
    .rst        (rst),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  sst_shreg #(.WORD_W(WORD_W)) shreg_i (
    .clk     (clk),
    .rst     (rst),
    .load_i  (sh_load),
    .word_i  (load_word),
    .shift_i (sh_shift),
    .clr_i   (sh_clr),
    .msb_o   (sdata_o),
    .last_o  (sh_last)
  );

  sst_ctrl #(
    .CNT_W (CNT_W),
    .SETUP (SETUP_E),
    .LO    (LO_E),
    .HI    (HI_E),
    .HOLD  (HOLD_E)
  ) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .req_i      (start_i | clear_i),
    .zero_i     (tmr_zero),
    .last_i     (sh_last),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .sh_load_o  (sh_load),
    .sh_shift_o (sh_shift),
    .sh_clr_o   (sh_clr),
    .strobe_n_o (strobe_n_o),
    .sclk_o     (sclk_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );
endmodule

// File: rtl/sst_chk.sv
module sst_chk #(
  parameter int WORD_W     = 16,
  parameter int SETUP_CYC  = 2,
  parameter int CLK_LO_CYC = 2,
  parameter int HOLD_CYC   = 13
) (
  input logic clk,
  input logic rst,
  input logic strobe_n_o,
  input logic sclk_o,
  input logic sdata_o,
  input logic busy_o,
  input logic done_o
);
  localparam int CW = 16;

  logic          stb_q, sclk_q;
  logic [CW-1:0] rises_q, since_rise_q, since_fall_q;
  logic          sclk_rise, stb_fall;

  assign sclk_rise = sclk_o && !sclk_q;
  assign stb_fall  = !strobe_n_o && stb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q        <= 1'b1;
      sclk_q       <= 1'b1;
      rises_q      <= '0;
      since_rise_q <= '0;
      since_fall_q <= '0;
    end else begin
      stb_q  <= strobe_n_o;
      sclk_q <= sclk_o;
      if (stb_fall) rises_q <= '0;
      else if (sclk_rise) rises_q <= rises_q + 1'b1;
      if (sclk_rise) since_rise_q <= CW'(1);
      else if (since_rise_q != '1) since_rise_q <= since_rise_q + 1'b1;
      if (stb_fall) since_fall_q <= CW'(1);
      else if (since_fall_q != '1) since_fall_q <= since_fall_q + 1'b1;
    end
  end

  // R1
  idle_levels_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (strobe_n_o && sclk_o && !sdata_o));

  // R11
  sclk_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    !sclk_o |-> !strobe_n_o);

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sclk_o |=> $stable(sdata_o));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8
  done_at_release_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (strobe_n_o && !stb_q && !busy_o));

  // R11
  edge_count_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe_n_o && !stb_q) |-> (rises_q == CW'(WORD_W)));

  // R7
  hold_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe_n_o && !stb_q) |-> (since_rise_q >= CW'(HOLD_CYC)));

  // R5
  setup_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && !strobe_n_o && rises_q == '0 && !stb_fall)
      |-> (since_fall_q >= CW'(SETUP_CYC + CLK_LO_CYC)));
endmodule

bind slot_sel_tx sst_chk #(
  .WORD_W     (WORD_W),
  .SETUP_CYC  (SETUP_E),
  .CLK_LO_CYC (LO_E),
  .HOLD_CYC   (HOLD_E)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .strobe_n_o (strobe_n_o),
  .sclk_o     (sclk_o),
  .sdata_o    (sdata_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/slot_sel_tx_tb_top.sv
`timescale 1ns/1ps
module slot_sel_tx_tb_top;
  localparam int W     = 16;
  localparam int SETUP = 2;
  localparam int LO    = 2;
  localparam int HI    = 3;
  localparam int HOLD  = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic clear_i = 1'b0;
  logic [W-1:0] word_i = '0;
  logic strobe_n_o, sclk_o, sdata_o, busy_o, done_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  slot_sel_tx #(
    .WORD_W(W), .SETUP_CYC(SETUP), .CLK_LO_CYC(LO), .CLK_HI_CYC(HI), .HOLD_CYC(HOLD)
  ) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .clear_i(clear_i), .word_i(word_i),
    .strobe_n_o(strobe_n_o), .sclk_o(sclk_o), .sdata_o(sdata_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  // receiver model sampled away from the active edge
  logic prev_stb = 1'b1, prev_sclk = 1'b1, prev_data = 1'b0;
  logic [W-1:0] cap;
  int rises, t_fall, t_first, t_last, t_end, frames;
  bit data_bad;

  initial begin
    cap = '0; rises = 0; t_fall = 0; t_first = 0; t_last = 0; t_end = 0;
    frames = 0; data_bad = 0;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stb && !strobe_n_o) begin
        t_fall = cyc; rises = 0; cap = '0; data_bad = 0;
      end
      if (!prev_sclk && sdata_o != prev_data) data_bad = 1;
      if (!prev_sclk && sclk_o && !strobe_n_o) begin
        if (rises == 0) t_first = cyc;
        t_last = cyc;
        cap = {cap[W-2:0], sdata_o};
        rises++;
      end
      if (!prev_stb && strobe_n_o) begin
        t_end = cyc; frames++;
      end
    end
    prev_stb = strobe_n_o; prev_sclk = sclk_o; prev_data = sdata_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_first();
    return SETUP + LO;
  endfunction
  function automatic int exp_span();
    return (W - 1) * (LO + HI);
  endfunction

  // sends one request; optional second request mid-frame
  task automatic run_frame(input logic [W-1:0] w, input bit use_start, input bit use_clear,
                           input logic [W-1:0] exp_w, input bit poke_busy);
    int nframes, guard;
    nframes = frames;
    @(negedge clk);
    word_i = w; start_i = use_start; clear_i = use_clear;
    @(negedge clk);
    start_i = 0; clear_i = 0;
    chk(busy_o == 1 && strobe_n_o == 0, "R2", {busy_o, strobe_n_o}, 2'b10);
    if (poke_busy) begin
      repeat (7) @(negedge clk);
      word_i = ~w; start_i = 1;
      @(negedge clk);
      start_i = 0; clear_i = 1;
      @(negedge clk);
      clear_i = 0;
    end
    guard = 0;
    while (!done_o && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    chk(done_o == 1, "R8 done seen", done_o, 1);
    chk(busy_o == 0 && strobe_n_o == 1, "R8 busy/strobe at done", {busy_o, strobe_n_o}, 2'b01);
    @(negedge clk);
    chk(done_o == 0, "R8 single pulse", done_o, 0);
    chk(cap == exp_w, "R3/R10 word", cap, exp_w);
    chk(rises == W, "R11 edge count", rises, W);
    chk(t_first - t_fall == exp_first(), "R5 setup", t_first - t_fall, exp_first());
    chk(t_last - t_first == exp_span(), "R6 spacing", t_last - t_first, exp_span());
    chk(t_end - t_last == HOLD, "R7 hold", t_end - t_last, HOLD);
    chk(!data_bad, "R4 data stable", data_bad, 0);
    chk(strobe_n_o && sclk_o && !sdata_o && !busy_o, "R1 idle",
        {strobe_n_o, sclk_o, sdata_o, busy_o}, 4'b1100);
    if (poke_busy) begin
      repeat (6) @(negedge clk);
      chk(busy_o == 0 && frames == nframes + 1, "R9 no extra frame", frames - nframes, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(strobe_n_o && sclk_o && !sdata_o && !busy_o && !done_o, "R1 reset",
        {strobe_n_o, sclk_o, sdata_o, busy_o, done_o}, 5'b11000);
    run_frame(16'hFFFF, 1, 0, 16'hFFFF, 0);
    run_frame(16'h0000, 1, 0, 16'h0000, 0);
    run_frame(16'h8001, 1, 0, 16'h8001, 0);
    run_frame(16'h5AA5, 1, 0, 16'h5AA5, 0);
    // R10: clear forces zero, and wins over start
    run_frame(16'hBEEF, 0, 1, 16'h0000, 0);
    run_frame(16'h1234, 1, 1, 16'h0000, 0);
    // R9: requests during busy ignored
    run_frame(16'hC3C3, 1, 0, 16'hC3C3, 1);
    for (int i = 0; i < 10; i++) begin
      logic [W-1:0] rw;
      rw = W'($urandom);
      run_frame(rw, 1, 0, rw, (i % 4) == 3);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule